// File: doc/BRIEF.md
# Arm Capacitor Balancer by Gate-Signal Exchange

This block sits between the carrier-based modulator of one converter arm and the gate drivers of its N series modules. The modulator produces N stacked switching signals, ordered so that a lower-numbered signal is on at least as long as any higher-numbered one. Only one of them, the active signal named by `act_idx`, toggles within a carrier period. The block does not alter those signals. It only decides which module receives which signal, and so it steers charge towards the weakest module and away from the strongest one.

Each transition of `sync_in` marks a carrier peak (rising) or valley (falling). At such a transition the block captures the module voltage samples, the sign of the arm current and the active index. A sequential scan then locates the highest- and lowest-voltage modules. If the exchange rule is met, the block swaps two entries in a pair of mutually inverse permutation tables (module to signal, signal to module). A crossbar drives every gate output from the signal its module currently owns. An exchange only ever involves two modules that both hold a steady level at that instant, so it adds no transition to any gate.

Top module: `mmc_swap_balancer`

## Requirements
- R1: After reset every module i is routed to switching signal i (identity mapping in both tables).
- R2: At all times `gate_o[i]` equals `sw_sig[k]`, where k is the signal index currently assigned to module i; the assignment is a permutation of 0..N-1.
- R3: On a rising `sync_in` transition with positive current (`cur_pos`=1, `cur_neg`=0), if the minimum-voltage module holds a signal index above the captured active index, it exchanges signals with the module that holds the active index.
- R4: On a rising transition with negative current (`cur_neg`=1, `cur_pos`=0), the same exchange is made for the maximum-voltage module when its signal index is above the active index.
- R5: On a falling transition with positive current, the maximum-voltage module exchanges with the active-index holder when its signal index is below the active index.
- R6: On a falling transition with negative current, the minimum-voltage module exchanges with the active-index holder when its signal index is below the active index.
- R7: A transition causes at most one exchange. An exchange changes the assignment of exactly two modules, and when no condition holds the mapping is left as it was.
- R8: When several modules share the maximum or minimum voltage, the one with the lowest module index is selected.
- R9: With zero current (`cur_pos`=0 and `cur_neg`=0) no exchange takes place.
- R10: While `bal_en` is low at the decision cycle the mapping stays frozen.
- R11: Voltages, current sign and active index are captured at the clock edge that first sees the new `sync_in` level. Changes after that edge do not affect the outcome. The new mapping appears at the gates N+1 clock edges after that capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bal_en | input | 1 | Balancing enable; low freezes the mapping |
| sync_in | input | 1 | Carrier sync: high from peak to valley |
| act_idx | input | IW | Index of the switching signal that toggles this period |
| sw_sig | input | N_MOD | Stacked switching signals from the modulator |
| volt_flat | input | N_MOD*VW | Module voltage samples, module i in bits [i*VW +: VW], unsigned |
| cur_pos | input | 1 | Arm current is positive (charging) |
| cur_neg | input | 1 | Arm current is negative (discharging) |
| gate_o | output | N_MOD | Gate command per module |

## Verification
The checks assume that `sync_in` is synchronous to `clk` and does not change again while a scan or decision is still in progress. They also assume that `cur_pos` and `cur_neg` are never high together and that `act_idx` is below N_MOD. The stimulus changes `sync_in` only on falling clock edges and waits N+4 cycles between transitions. It draws current sign, active index and enable from a small set of legal codes, and uses 3-bit voltage values so that ties occur often.

// File: rtl/mbal_pkg.sv
package mbal_pkg;

  typedef enum logic [1:0] {
    CUR_ZERO = 2'd0,
    CUR_POS  = 2'd1,
    CUR_NEG  = 2'd2
  } cur_sign_e;

  function automatic cur_sign_e decode_sign(input logic pos, input logic neg);
    if (pos && !neg) return CUR_POS;
    if (neg && !pos) return CUR_NEG;
    return CUR_ZERO;
  endfunction

endpackage

// File: rtl/mbal_capture.sv
module mbal_capture
  import mbal_pkg::*;
#(
  parameter int N_MOD = 4,
  parameter int VW    = 12,
  parameter int IW    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sync_in,
  input  logic [N_MOD*VW-1:0]   volt_in,
  input  logic                  cur_pos,
  input  logic                  cur_neg,
  input  logic [IW-1:0]         act_in,
  input  logic                  search_busy,
  output logic                  start_o,
  output logic [N_MOD*VW-1:0]   snap_volt_o,
  output cur_sign_e             snap_sign_o,
  output logic                  snap_rise_o,
  output logic [IW-1:0]         snap_act_o
);

  logic                sync_q, sync_d;
  logic                start_q, start_d;
  logic [N_MOD*VW-1:0] volt_q, volt_d;
  cur_sign_e           sign_q, sign_d;
  logic                rise_q, rise_d;
  logic [IW-1:0]       act_q, act_d;
  logic                accept;

  assign accept = (sync_in ^ sync_q) & ~search_busy & ~start_q;

  always_comb begin
    sync_d  = sync_in;
    start_d = accept;
    volt_d  = volt_q;
    sign_d  = sign_q;
    rise_d  = rise_q;
    act_d   = act_q;
    if (accept) begin
      volt_d = volt_in;
      sign_d = decode_sign(cur_pos, cur_neg);
      rise_d = sync_in;
      act_d  = act_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      start_q <= 1'b0;
      volt_q  <= '0;
      sign_q  <= CUR_ZERO;
      rise_q  <= 1'b0;
      act_q   <= '0;
    end else begin
      sync_q  <= sync_d;
      start_q <= start_d;
      volt_q  <= volt_d;
      sign_q  <= sign_d;
      rise_q  <= rise_d;
      act_q   <= act_d;
    end
  end

  assign start_o     = start_q;
  assign snap_volt_o = volt_q;
  assign snap_sign_o = sign_q;
  assign snap_rise_o = rise_q;
  assign snap_act_o  = act_q;

endmodule

// File: rtl/mbal_extreme_search.sv
module mbal_extreme_search #(
  parameter int N_MOD = 4,
  parameter int VW    = 12,
  parameter int IW    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [N_MOD*VW-1:0] volt_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [IW-1:0]       max_idx_o,
  output logic [IW-1:0]       min_idx_o
);

  localparam logic [IW-1:0] LAST = IW'(N_MOD - 1);

  logic          run_q, run_d;
  logic          done_q, done_d;
  logic [IW-1:0] cnt_q, cnt_d;
  logic [VW-1:0] max_v_q, max_v_d, min_v_q, min_v_d;
  logic [IW-1:0] max_i_q, max_i_d, min_i_q, min_i_d;
  logic [VW-1:0] samp;

  assign samp = volt_i[VW*cnt_q +: VW];

  always_comb begin
    run_d   = run_q;
    done_d  = 1'b0;
    cnt_d   = cnt_q;
    max_v_d = max_v_q;
    min_v_d = min_v_q;
    max_i_d = max_i_q;
    min_i_d = min_i_q;
    if (start_i) begin
      max_v_d = volt_i[VW-1:0];
      min_v_d = volt_i[VW-1:0];
      max_i_d = '0;
      min_i_d = '0;
      cnt_d   = IW'(1);
      run_d   = (N_MOD > 1);
      done_d  = (N_MOD == 1);
    end else if (run_q) begin
      // strict comparisons keep the earliest (lowest index) module on ties
      if (samp > max_v_q) begin
        max_v_d = samp;
        max_i_d = cnt_q;
      end
      if (samp < min_v_q) begin
        min_v_d = samp;
        min_i_d = cnt_q;
      end
      if (cnt_q == LAST) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      max_v_q <= '0;
      min_v_q <= '0;
      max_i_q <= '0;
      min_i_q <= '0;
    end else begin
      run_q   <= run_d;
      done_q  <= done_d;
      cnt_q   <= cnt_d;
      max_v_q <= max_v_d;
      min_v_q <= min_v_d;
      max_i_q <= max_i_d;
      min_i_q <= min_i_d;
    end
  end

  assign busy_o    = run_q | done_q;
  assign done_o    = done_q;
  assign max_idx_o = max_i_q;
  assign min_idx_o = min_i_q;

endmodule

// File: rtl/mbal_perm_table.sv
module mbal_perm_table
  import mbal_pkg::*;
#(
  parameter int N_MOD = 4,
  parameter int IW    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done_i,
  input  logic                bal_en_i,
  input  logic                rise_i,
  input  cur_sign_e           sign_i,
  input  logic [IW-1:0]       act_i,
  input  logic [IW-1:0]       max_i,
  input  logic [IW-1:0]       min_i,
  output logic [N_MOD*IW-1:0] m_flat_o,
  output logic [N_MOD*IW-1:0] is_flat_o,
  output logic                swap_o
);

  logic [IW-1:0] m_q  [N_MOD];
  logic [IW-1:0] m_d  [N_MOD];
  logic [IW-1:0] is_q [N_MOD];
  logic [IW-1:0] is_d [N_MOD];
  logic [IW-1:0] cand, cand_sig, partner;
  logic          cond, swap;

  always_comb begin
    // rising+positive and falling+negative pick the weakest module
    cand     = (rise_i ^ (sign_i == CUR_NEG)) ? min_i : max_i;
    cand_sig = m_q[cand];
    partner  = is_q[act_i];
    cond     = rise_i ? (cand_sig > act_i) : (cand_sig < act_i);
    swap     = done_i & bal_en_i & (sign_i != CUR_ZERO) & cond;
    m_d      = m_q;
    is_d     = is_q;
    if (swap) begin
      m_d[cand]      = act_i;
      m_d[partner]   = cand_sig;
      is_d[act_i]    = cand;
      is_d[cand_sig] = partner;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_MOD; k++) begin
        m_q[k]  <= IW'(k);
        is_q[k] <= IW'(k);
      end
    end else begin
      m_q  <= m_d;
      is_q <= is_d;
    end
  end

  for (genvar g = 0; g < N_MOD; g++) begin : g_flat
    assign m_flat_o[g*IW +: IW]  = m_q[g];
    assign is_flat_o[g*IW +: IW] = is_q[g];
  end

  assign swap_o = swap;

endmodule

// File: rtl/mbal_crossbar.sv
module mbal_crossbar #(
  parameter int N_MOD = 4,
  parameter int IW    = 2
) (
  input  logic [N_MOD-1:0]    sig_i,
  input  logic [N_MOD*IW-1:0] m_flat_i,
  output logic [N_MOD-1:0]    gate_o
);

  for (genvar g = 0; g < N_MOD; g++) begin : g_route
    assign gate_o[g] = sig_i[m_flat_i[g*IW +: IW]];
  end

endmodule

// File: rtl/mmc_swap_balancer.sv
module mmc_swap_balancer
  import mbal_pkg::*;
#(
  parameter int N_MOD = 4,
  parameter int VW    = 12,
  localparam int IW   = (N_MOD > 1) ? $clog2(N_MOD) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bal_en,
  input  logic                sync_in,
  input  logic [IW-1:0]       act_idx,
  input  logic [N_MOD-1:0]    sw_sig,
  input  logic [N_MOD*VW-1:0] volt_flat,
  input  logic                cur_pos,
  input  logic                cur_neg,
  output logic [N_MOD-1:0]    gate_o
);

  logic [1:0]          rst_ff;
  logic                rst_core_n;
  logic                start;
  logic [N_MOD*VW-1:0] snap_volt;
  cur_sign_e           snap_sign;
  logic                snap_rise;
  logic [IW-1:0]       snap_act;
  logic                srch_busy, srch_done;
  logic [IW-1:0]       max_idx, min_idx;
  logic [N_MOD*IW-1:0] m_flat, is_flat;
  logic                swap_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_core_n = rst_ff[1];

  mbal_capture #(.N_MOD(N_MOD), .VW(VW), .IW(IW)) u_cap (
    .clk(clk), .rst_n(rst_core_n), .sync_in(sync_in), .volt_in(volt_flat),
    .cur_pos(cur_pos), .cur_neg(cur_neg), .act_in(act_idx),
    .search_busy(srch_busy), .start_o(start), .snap_volt_o(snap_volt),
    .snap_sign_o(snap_sign), .snap_rise_o(snap_rise), .snap_act_o(snap_act)
  );

  mbal_extreme_search #(.N_MOD(N_MOD), .VW(VW), .IW(IW)) u_srch (
    .clk(clk), .rst_n(rst_core_n), .start_i(start), .volt_i(snap_volt),
    .busy_o(srch_busy), .done_o(srch_done), .max_idx_o(max_idx), .min_idx_o(min_idx)
  );

  mbal_perm_table #(.N_MOD(N_MOD), .IW(IW)) u_tab (
    .clk(clk), .rst_n(rst_core_n), .done_i(srch_done), .bal_en_i(bal_en),
    .rise_i(snap_rise), .sign_i(snap_sign), .act_i(snap_act),
    .max_i(max_idx), .min_i(min_idx), .m_flat_o(m_flat), .is_flat_o(is_flat),
    .swap_o(swap_go)
  );

  mbal_crossbar #(.N_MOD(N_MOD), .IW(IW)) u_xbar (
    .sig_i(sw_sig), .m_flat_i(m_flat), .gate_o(gate_o)
  );

endmodule

// File: rtl/mbal_checker.sv
module mbal_checker #(
  parameter int N_MOD = 4,
  parameter int IW    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bal_en,
  input  logic                sync_in,
  input  logic                srch_busy,
  input  logic [N_MOD-1:0]    sw_sig,
  input  logic [N_MOD-1:0]    gate_o,
  input  logic [N_MOD*IW-1:0] m_flat,
  input  logic [N_MOD*IW-1:0] is_flat
);

  logic                prev_vld;
  logic [N_MOD*IW-1:0] m_prev;
  int                  chg_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_vld <= 1'b0;
      m_prev   <= '0;
    end else begin
      prev_vld <= 1'b1;
      m_prev   <= m_flat;
    end
  end

  always_comb begin
    chg_cnt = 0;
    for (int i = 0; i < N_MOD; i++)
      if (m_flat[i*IW +: IW] != m_prev[i*IW +: IW]) chg_cnt++;
  end

  AST_PAIR_SWAP: assert property (@(posedge clk) disable iff (!rst_n) prev_vld |-> (chg_cnt == 0 || chg_cnt == 2)); // R7
  AST_GATE_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n) $countones(gate_o) == $countones(sw_sig)); // R2
  AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !bal_en |=> $stable(m_flat)); // R10
  AST_SYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (sync_in != $past(sync_in)) |-> !srch_busy); // R11

  for (genvar g = 0; g < N_MOD; g++) begin : g_inv
    AST_TABLE_INVERSE: assert property (@(posedge clk) disable iff (!rst_n) is_flat[IW*m_flat[g*IW +: IW] +: IW] == IW'(g)); // R7
  end

endmodule

bind mmc_swap_balancer mbal_checker #(.N_MOD(N_MOD), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bal_en(bal_en), .sync_in(sync_in),
  .srch_busy(srch_busy), .sw_sig(sw_sig), .gate_o(gate_o),
  .m_flat(m_flat), .is_flat(is_flat)
);

// File: tb/tb_mmc_swap_balancer.sv
module tb_mmc_swap_balancer;

  localparam int N  = 4;
  localparam int VW = 8;
  localparam int IW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bal_en = 1'b1;
  logic            sync_in = 1'b0;
  logic            cur_pos = 1'b0;
  logic            cur_neg = 1'b0;
  logic [IW-1:0]   act_idx = '0;
  logic [N-1:0]    sw_sig = '0;
  logic [N*VW-1:0] volt_flat = '0;
  logic [N-1:0]    gate_o;

  int errs = 0;
  int checks = 0;
  int mm [N];
  int ism [N];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  mmc_swap_balancer #(.N_MOD(N), .VW(VW)) dut (
    .clk(clk), .rst_n(rst_n), .bal_en(bal_en), .sync_in(sync_in),
    .act_idx(act_idx), .sw_sig(sw_sig), .volt_flat(volt_flat),
    .cur_pos(cur_pos), .cur_neg(cur_neg), .gate_o(gate_o)
  );

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: gate=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic probe_all(input string tag);
    logic [N-1:0] pat, exp;
    for (int x = 0; x < N; x++) begin
      sw_sig = N'(1 << x);
      #1;
      chk(tag, gate_o, N'(1 << ism[x]));
    end
    step_lfsr();
    pat = lfsr[N-1:0];
    for (int i = 0; i < N; i++) exp[i] = pat[mm[i]];
    sw_sig = pat;
    #1;
    chk("R2", gate_o, exp);
  endtask

  function automatic void model(input logic rise, input logic cp, input logic cn,
                                input int act, input logic [N*VW-1:0] v, input logic en);
    int mx, mn, cand, cs, p;
    logic cond;
    mx = 0;
    mn = 0;
    for (int i = 1; i < N; i++) begin
      if (v[i*VW +: VW] > v[mx*VW +: VW]) mx = i;
      if (v[i*VW +: VW] < v[mn*VW +: VW]) mn = i;
    end
    if (!en || (cp == cn)) return;
    cand = (rise ^ cn) ? mn : mx;
    cs   = mm[cand];
    cond = rise ? (cs > act) : (cs < act);
    if (cond) begin
      p        = ism[act];
      mm[cand] = act;
      mm[p]    = cs;
      ism[act] = cand;
      ism[cs]  = p;
    end
  endfunction

  task automatic run_edge(input logic [N*VW-1:0] v, input logic cp, input logic cn,
                          input int act, input logic en, input string tag);
    @(negedge clk);
    volt_flat = v;
    cur_pos   = cp;
    cur_neg   = cn;
    act_idx   = IW'(act);
    bal_en    = en;
    sync_in   = ~sync_in;
    model(sync_in, cp, cn, act, v, en);
    repeat (N + 4) @(posedge clk);
    @(negedge clk);
    probe_all(tag);
  endtask

  initial begin
    logic [N*VW-1:0] v;
    logic cp, cn, en, rise;
    int act, old, tgt;
    string tag;
    for (int i = 0; i < N; i++) begin
      mm[i]  = i;
      ism[i] = i;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    probe_all("R1");

    // R9: rising edge, zero current, would otherwise be eligible
    v = '0;
    v[3*VW +: VW] = 8'd1;
    run_edge(v, 1'b0, 1'b0, 0, 1'b1, "R9");

    // R8: falling edge, all equal; module 0 must win the tie and take signal 2
    for (int i = 0; i < N; i++) v[i*VW +: VW] = 8'd5;
    run_edge(v, 1'b1, 1'b0, 2, 1'b1, "R8");

    // sweep over edges, currents, active indices and enable
    for (int k = 0; k < 320; k++) begin
      for (int i = 0; i < N; i++) begin
        step_lfsr();
        v[i*VW +: VW] = VW'(lfsr[2:0]);
      end
      step_lfsr();
      cp  = (lfsr[1:0] == 2'd1) || (lfsr[1:0] == 2'd3);
      cn  = (lfsr[1:0] == 2'd2);
      act = int'(lfsr[5:4]);
      en  = (lfsr[9:7] != 3'd0);
      rise = ~sync_in;
      if (!en) tag = "R10";
      else if (!cp && !cn) tag = "R9";
      else if (rise && cp) tag = "R3";
      else if (rise && cn) tag = "R4";
      else if (cp) tag = "R5";
      else tag = "R6";
      run_edge(v, cp, cn, act, en, tag);
    end

    // R11: latency and capture of the sampled inputs
    @(negedge clk);
    rise = ~sync_in;
    act  = rise ? 0 : 3;
    tgt  = rise ? ism[3] : ism[0];
    for (int i = 0; i < N; i++) v[i*VW +: VW] = 8'd4;
    v[tgt*VW +: VW] = rise ? 8'd1 : 8'd7;
    volt_flat = v;
    cur_pos = 1'b1;
    cur_neg = 1'b0;
    bal_en  = 1'b1;
    act_idx = IW'(act);
    sw_sig  = N'(1 << act);
    sync_in = ~sync_in;
    old = ism[act];
    model(rise, 1'b1, 1'b0, act, v, 1'b1);
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < N; i++) volt_flat[i*VW +: VW] = 8'd4;
    volt_flat[ism[1]*VW +: VW] = rise ? 8'd0 : 8'd9;
    act_idx = 2'd1;
    repeat (N) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R11", gate_o, N'(1 << old));
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R11", gate_o, N'(1 << ism[act]));
    probe_all("R11");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule